// File: doc/BRIEF.md
# Linked Descriptor Chain DMA Engine

This block is a bus-master data mover that follows a chain of work items held in system memory. The host loads the address of the first item into a register and issues a start command. From then on the engine works alone: it reads each five-word descriptor, moves data between the buffer it names and one of two streaming ports, writes a completion word back into the descriptor, and then follows the descriptor's link to the next one. A null link, a memory fault or a host abort returns the engine to its stopped state.

Each descriptor may ask for a host notification. The engine then sets a level interrupt and carries straight on with the next descriptor. The line stays set until the host touches the acknowledge register. A host that flags only some descriptors can therefore gather many completions under one interrupt and read their status words in memory afterwards.

Top module: `desc_chain_dma`

## Requirements
- R1: A descriptor is five consecutive 32-bit words at a word-aligned address D: D+0 link, D+4 buffer address, D+8 command (opcode in bits 31:24, byte length in bits 15:0), D+12 status, D+16 flags (bit 0 = interrupt request). The engine reads D+0, D+4, D+8 and D+16, and walks descriptors in link order.
- R2: Host registers by `reg_addr`: 0 = control (write bit 0 = start, bit 1 = abort), 1 = head address (read/write), 2 = state (bit 0 = busy, bits 31:2 = current descriptor address), 3 = interrupt acknowledge. A start while stopped loads the head address and sets busy on the next cycle. A start while busy is ignored.
- R3: Opcode 0x01 reads ceil(length/4) words from the buffer in rising address order and presents each on the output stream. A word is held stable until `tx_ready` is high.
- R4: Opcode 0x02 takes ceil(length/4) words from the input stream and writes them to consecutive buffer words.
- R5: After each processed descriptor the engine writes its status word: bit 31 = done, bit 30 = error, bits 15:0 = bytes transferred (the full length on success).
- R6: Any other opcode moves no data and gets status 0xC0000000. The chain then continues through the link.
- R7: An error response from memory ends the descriptor. Its status gets bits 31 and 30 set and bytes = 4 x the words completed, and the engine stops whatever the link holds.
- R8: When the flags bit 0 is set, `irq` is high from the cycle after the status write is acknowledged, and the engine continues without waiting.
- R9: `irq` stays high until a read or write of register 3. It is low the cycle after that access, unless a new flagged completion falls in the same cycle, in which case it stays high.
- R10: A zero link stops the engine after its status write. Busy clears, and the state register keeps the last descriptor's address.
- R11: An abort while busy lets the current descriptor finish, including its status write, then stops the engine. No later descriptor is read or written.
- R12: A memory request holds `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` steady until `mem_ack`. Every address is word aligned. No request is made while the engine is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_en | input | 1 | Host register access strobe, one cycle per access |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write request |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | One-cycle completion of the pending request |
| mem_err | input | 1 | Error response, valid with `mem_ack` |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| tx_valid | output | 1 | Output stream word valid |
| tx_ready | input | 1 | Output stream sink ready |
| tx_data | output | 32 | Output stream word |
| rx_valid | input | 1 | Input stream word valid |
| rx_ready | output | 1 | Engine ready for an input word |
| rx_data | input | 32 | Input stream word |
| irq | output | 1 | Level interrupt |

## Verification
A start write is seen as busy one cycle later. The interrupt rises one cycle after the status write's acknowledge, and an acknowledge access drops it one cycle after the access. Everything else depends on memory and stream latency. For that reason the bench waits on the busy bit going low and only then compares status words, buffer contents and logged stream words against values derived from the requirements. For the two single-cycle relations, interrupt set and interrupt acknowledge, the bench drives the host access at a falling edge in the exact cycle the memory model returns the status acknowledge, then samples `irq` at the next falling edge. The checker module covers the cycle-level handshake rules.

// File: rtl/dcd_pkg.sv
// Package for the descriptor chain engine: engine states, opcodes, the
// descriptor word offsets and the register indices. Assumes 32-bit words and
// byte addressing.
package dcd_pkg;

    localparam int WORD_W   = 32;
    localparam int LEN_W    = 16;
    localparam int DESC_WORDS = 5;

    localparam logic [7:0] OP_TO_STREAM   = 8'h01;
    localparam logic [7:0] OP_FROM_STREAM = 8'h02;

    // word index inside a descriptor (position matters: host builds these)
    localparam logic [2:0] W_LINK  = 3'd0;
    localparam logic [2:0] W_BUF   = 3'd1;
    localparam logic [2:0] W_CMD   = 3'd2;
    localparam logic [2:0] W_STAT  = 3'd3;
    localparam logic [2:0] W_FLAGS = 3'd4;

    localparam logic [1:0] RG_CTRL = 2'd0;
    localparam logic [1:0] RG_HEAD = 2'd1;
    localparam logic [1:0] RG_STATE = 2'd2;
    localparam logic [1:0] RG_ACK  = 2'd3;

    typedef enum logic [3:0] {
        ST_STOP,
        ST_FETCH,
        ST_DECODE,
        ST_RD_MEM,
        ST_RD_OUT,
        ST_WR_IN,
        ST_WR_MEM,
        ST_STATUS
    } eng_state_t;

endpackage

// File: rtl/dcd_regs.sv
// Host register file: decodes start, abort and acknowledge accesses and holds
// the head address. Assumes one-cycle access strobes. Read data is
// combinational.
module dcd_regs
    import dcd_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_en,
    input  logic          reg_we,
    input  logic [1:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          busy,
    input  logic [AW-1:0] cur_addr,
    output logic [AW-1:0] head_addr,
    output logic          start_cmd,
    output logic          abort_cmd,
    output logic          ack_access
);

    logic wr_ctrl;

    // decode the one-cycle commands from the access strobe
    always_comb begin
        wr_ctrl    = reg_en && reg_we && (reg_addr == RG_CTRL);
        start_cmd  = wr_ctrl && reg_wdata[0] && !busy;
        abort_cmd  = wr_ctrl && reg_wdata[1] && busy;
        ack_access = reg_en && (reg_addr == RG_ACK);
    end

    // head address register, forced word aligned
    always_ff @(posedge clk) begin
        if (!rst_n)
            head_addr <= '0;
        else if (reg_en && reg_we && reg_addr == RG_HEAD)
            head_addr <= {reg_wdata[AW-1:2], 2'b00};
    end

    // read multiplexer
    always_comb begin
        case (reg_addr)
            RG_HEAD:  reg_rdata = head_addr;
            RG_STATE: reg_rdata = {cur_addr[AW-1:2], 1'b0, busy};
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dcd_irq.sv
// Level interrupt latch: a completion request sets it, a host acknowledge
// clears it, and a set in the same cycle as a clear wins.
module dcd_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic irq
);

    // sticky interrupt flag with set priority
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= set_req | (irq & ~clr_req);
    end

endmodule

// File: rtl/dcd_engine.sv
// Descriptor walker: fetches a descriptor, moves its data between memory and
// a stream port, writes the completion word and follows the link. Assumes a
// single outstanding memory request, answered by one mem_ack pulse.
module dcd_engine
    import dcd_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_cmd,
    input  logic          abort_cmd,
    input  logic [AW-1:0] head_addr,
    output logic          busy,
    output logic [AW-1:0] cur_addr,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic          mem_err,
    input  logic [31:0]   mem_rdata,
    output logic          tx_valid,
    input  logic          tx_ready,
    output logic [31:0]   tx_data,
    input  logic          rx_valid,
    output logic          rx_ready,
    input  logic [31:0]   rx_data,
    output logic          irq_set
);

    localparam int CNT_W = LEN_W + 1;

    eng_state_t        state;
    logic [AW-1:0]     link_q, buf_q;
    logic [7:0]        op_q;
    logic [LEN_W-1:0]  len_q;
    logic              irq_flag_q;
    logic [2:0]        widx;
    logic [CNT_W-1:0]  wdone, nwords;
    logic [31:0]       hold_q;
    logic              err_q, fatal_q, abort_q;
    logic [LEN_W-1:0]  bytes_done;
    logic              last_word;

    // derived counts for the data phase
    always_comb begin
        nwords     = ({1'b0, len_q} + CNT_W'(3)) >> 2;
        last_word  = (wdone + CNT_W'(1)) == nwords;
        bytes_done = err_q ? LEN_W'(wdone << 2) : len_q;
        busy       = (state != ST_STOP);
    end

    // memory and stream outputs from the current state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        tx_valid  = (state == ST_RD_OUT);
        tx_data   = hold_q;
        rx_ready  = (state == ST_WR_IN);
        irq_set   = (state == ST_STATUS) && mem_ack && irq_flag_q;
        case (state)
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = cur_addr + {{(AW-5){1'b0}}, widx, 2'b00};
            end
            ST_RD_MEM: begin
                mem_req  = 1'b1;
                mem_addr = buf_q + AW'({wdone, 2'b00});
            end
            ST_WR_MEM: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = buf_q + AW'({wdone, 2'b00});
                mem_wdata = hold_q;
            end
            ST_STATUS: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_addr + AW'({W_STAT, 2'b00});
                mem_wdata = {1'b1, err_q, 14'd0, bytes_done};
            end
            default: ;
        endcase
    end

    // sequencer for fetch, data movement, status write and link following
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_STOP;
            cur_addr   <= '0;
            link_q     <= '0;
            buf_q      <= '0;
            op_q       <= '0;
            len_q      <= '0;
            irq_flag_q <= 1'b0;
            widx       <= '0;
            wdone      <= '0;
            hold_q     <= '0;
            err_q      <= 1'b0;
            fatal_q    <= 1'b0;
            abort_q    <= 1'b0;
        end else begin
            if (abort_cmd)
                abort_q <= 1'b1;
            case (state)
                ST_STOP: if (start_cmd) begin
                    cur_addr <= head_addr;
                    abort_q  <= 1'b0;
                    fatal_q  <= 1'b0;
                    err_q    <= 1'b0;
                    widx     <= W_LINK;
                    state    <= ST_FETCH;
                end
                ST_FETCH: if (mem_ack) begin
                    if (mem_err) begin
                        err_q   <= 1'b1;
                        fatal_q <= 1'b1;
                        wdone   <= '0;
                        state   <= ST_STATUS;
                    end else begin
                        case (widx)
                            W_LINK:  link_q <= {mem_rdata[AW-1:2], 2'b00};
                            W_BUF:   buf_q  <= {mem_rdata[AW-1:2], 2'b00};
                            W_CMD: begin
                                op_q  <= mem_rdata[31:24];
                                len_q <= mem_rdata[LEN_W-1:0];
                            end
                            default: irq_flag_q <= mem_rdata[0];
                        endcase
                        if (widx == W_FLAGS)
                            state <= ST_DECODE;
                        widx <= (widx == W_CMD) ? W_FLAGS : widx + 3'd1;
                    end
                end
                ST_DECODE: begin
                    wdone <= '0;
                    if (op_q == OP_TO_STREAM)
                        state <= (nwords == '0) ? ST_STATUS : ST_RD_MEM;
                    else if (op_q == OP_FROM_STREAM)
                        state <= (nwords == '0) ? ST_STATUS : ST_WR_IN;
                    else begin
                        err_q <= 1'b1;
                        state <= ST_STATUS;
                    end
                end
                ST_RD_MEM: if (mem_ack) begin
                    if (mem_err) begin
                        err_q   <= 1'b1;
                        fatal_q <= 1'b1;
                        state   <= ST_STATUS;
                    end else begin
                        hold_q <= mem_rdata;
                        state  <= ST_RD_OUT;
                    end
                end
                ST_RD_OUT: if (tx_ready) begin
                    wdone <= wdone + CNT_W'(1);
                    state <= last_word ? ST_STATUS : ST_RD_MEM;
                end
                ST_WR_IN: if (rx_valid) begin
                    hold_q <= rx_data;
                    state  <= ST_WR_MEM;
                end
                ST_WR_MEM: if (mem_ack) begin
                    if (mem_err) begin
                        err_q   <= 1'b1;
                        fatal_q <= 1'b1;
                        state   <= ST_STATUS;
                    end else begin
                        wdone <= wdone + CNT_W'(1);
                        state <= last_word ? ST_STATUS : ST_WR_IN;
                    end
                end
                ST_STATUS: if (mem_ack) begin
                    err_q <= 1'b0;
                    widx  <= W_LINK;
                    if (fatal_q || mem_err || abort_q || abort_cmd || link_q == '0)
                        state <= ST_STOP;
                    else begin
                        cur_addr <= link_q;
                        state    <= ST_FETCH;
                    end
                end
                default: state <= ST_STOP;
            endcase
        end
    end

endmodule

// File: rtl/desc_chain_dma.sv
// Top level of the descriptor chain engine: joins the host registers, the
// descriptor walker and the interrupt latch. Assumes a word-oriented memory
// port with one request in flight.
module desc_chain_dma
    import dcd_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_en,
    input  logic          reg_we,
    input  logic [1:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic          mem_err,
    input  logic [31:0]   mem_rdata,
    output logic          tx_valid,
    input  logic          tx_ready,
    output logic [31:0]   tx_data,
    input  logic          rx_valid,
    output logic          rx_ready,
    input  logic [31:0]   rx_data,
    output logic          irq
);

    logic          eng_busy, start_cmd, abort_cmd, host_ack, irq_set;
    logic [AW-1:0] head_addr, cur_addr;

    dcd_regs #(.AW(AW)) regs_i (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(eng_busy), .cur_addr(cur_addr), .head_addr(head_addr),
        .start_cmd(start_cmd), .abort_cmd(abort_cmd), .ack_access(host_ack)
    );

    dcd_engine #(.AW(AW)) eng_i (
        .clk(clk), .rst_n(rst_n), .start_cmd(start_cmd), .abort_cmd(abort_cmd),
        .head_addr(head_addr), .busy(eng_busy), .cur_addr(cur_addr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
        .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_data(rx_data), .irq_set(irq_set)
    );

    dcd_irq irq_i (
        .clk(clk), .rst_n(rst_n), .set_req(irq_set), .clr_req(host_ack),
        .irq(irq)
    );

endmodule

// File: rtl/dcd_checker.sv
// Protocol checker for desc_chain_dma, bound to the top. Assumes the
// synchronous active-low reset of the design.
module dcd_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          irq,
    input logic          irq_set,
    input logic          ack_access,
    input logic          busy,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          tx_valid,
    input logic          tx_ready,
    input logic [31:0]   tx_data,
    input logic          rx_ready
);

    assert_set_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set |=> irq);

    assert_irq_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(mem_ack && mem_we));

    assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack_access) |=> irq);

    assert_ack_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_access && !irq_set) |=> !irq);

    assert_mem_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) &&
                                  $stable(mem_we) && $stable(mem_wdata));

    assert_mem_align_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00);

    assert_stop_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req && !tx_valid && !rx_ready);

    assert_tx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_data));

endmodule

bind desc_chain_dma dcd_checker #(.AW(AW)) chk_i (
    .clk(clk), .rst_n(rst_n), .irq(irq), .irq_set(irq_set),
    .ack_access(host_ack), .busy(eng_busy), .mem_req(mem_req),
    .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_ready(rx_ready)
);

// File: tb/desc_chain_dma_tb_top.sv
module desc_chain_dma_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_en = 1'b0, reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        mem_req, mem_we, mem_ack = 1'b0, mem_err = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic        tx_valid, tx_ready, rx_valid, rx_ready, irq;
    logic [31:0] tx_data, rx_data;
    logic        tx_flip = 1'b0, rx_en = 1'b1;

    int checks = 0, fails = 0, cyc = 0;
    logic [31:0] mem [256];
    logic [31:0] tx_log [64];
    int tx_n = 0, rx_n = 0;

    always #5 clk = ~clk;

    desc_chain_dma dut_i (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
        .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_data(rx_data), .irq(irq)
    );

    assign tx_ready = tx_flip;
    assign rx_valid = rx_en && tx_flip;
    assign rx_data  = 32'hA500_0000 + rx_n;

    // memory responder: one ack per request, addresses from 0x400 fault
    always @(posedge clk) begin
        mem_ack <= 1'b0;
        mem_err <= 1'b0;
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_addr >= 32'h400) mem_err <= 1'b1;
            else if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
            else mem_rdata <= mem[mem_addr[9:2]];
        end
    end

    // stream sink/source bookkeeping and watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        tx_flip <= ~tx_flip;
        if (tx_valid && tx_ready) begin
            tx_log[tx_n[5:0]] <= tx_data;
            tx_n <= tx_n + 1;
        end
        if (rx_valid && rx_ready) rx_n <= rx_n + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_en = 1'b0;
    endtask

    task automatic put_desc(input int a, input int lnk, input int buff,
                            input logic [7:0] op, input logic [15:0] len, input logic flg);
        mem[a/4]     = lnk;
        mem[a/4 + 1] = buff;
        mem[a/4 + 2] = {op, 8'h00, len};
        mem[a/4 + 3] = 32'h0;
        mem[a/4 + 4] = {31'd0, flg};
    endtask

    task automatic wait_stop();
        logic [31:0] s;
        s = 32'h1;
        while (s[0]) reg_rd(2'd2, s);
    endtask

    task automatic run(input int head);
        reg_wr(2'd1, head);
        reg_wr(2'd0, 32'h1);
        wait_stop();
    endtask

    typedef struct packed {
        logic [7:0]  op;
        logic [15:0] len;
        logic        flg;
        logic [31:0] stat;
        logic [7:0]  ntx;
        logic [7:0]  nrx;
    } vec_t;

    localparam vec_t VEC [5] = '{
        '{8'h01, 16'd8,  1'b1, 32'h8000_0008, 8'd2, 8'd0},
        '{8'h02, 16'd12, 1'b0, 32'h8000_000C, 8'd0, 8'd3},
        '{8'h07, 16'd4,  1'b1, 32'hC000_0000, 8'd0, 8'd0},
        '{8'h01, 16'd5,  1'b0, 32'h8000_0005, 8'd2, 8'd0},
        '{8'h01, 16'd0,  1'b0, 32'h8000_0000, 8'd0, 8'd0}
    };

    initial begin
        logic [31:0] r;
        int t0, r0;
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state
        check("R12 reset mem_req", {31'd0, mem_req}, 32'h0);
        check("R8 reset irq", {31'd0, irq}, 32'h0);
        check("R3 reset tx_valid", {31'd0, tx_valid}, 32'h0);
        rst_n = 1'b1;
        reg_rd(2'd2, r);
        check("R2 reset state reg", r, 32'h0);

        // vector table: single descriptor at 0x100, buffer 0x200
        for (int v = 0; v < 5; v++) begin
            for (int i = 0; i < 8; i++) mem[32'h200/4 + i] = 32'h1000 + v * 16 + i;
            put_desc(32'h100, 0, 32'h200, VEC[v].op, VEC[v].len, VEC[v].flg);
            t0 = tx_n; r0 = rx_n;
            run(32'h100);
            check("R5 R6 status word", mem[32'h10C/4], VEC[v].stat);
            check("R3 tx word count", tx_n - t0, VEC[v].ntx);
            check("R4 rx word count", rx_n - r0, VEC[v].nrx);
            if (VEC[v].ntx != 0) begin
                check("R3 first tx word", tx_log[t0[5:0]], 32'h1000 + v * 16);
                check("R3 last tx word", tx_log[(t0 + VEC[v].ntx - 1) % 64],
                      32'h1000 + v * 16 + VEC[v].ntx - 1);
            end
            if (VEC[v].nrx != 0)
                for (int i = 0; i < VEC[v].nrx; i++)
                    check("R4 buffer word", mem[32'h200/4 + i], 32'hA500_0000 + r0 + i);
            check("R8 irq after flag", {31'd0, irq}, {31'd0, VEC[v].flg});
            reg_rd(2'd3, r);
            @(negedge clk);
            check("R9 irq cleared by ack read", {31'd0, irq}, 32'h0);
        end

        // chain of three: flagged, unknown opcode, plain; link order kept
        for (int i = 0; i < 3; i++) mem[32'h200/4 + 16 * i] = 32'h7700 + i;
        put_desc(32'h100, 32'h140, 32'h200, 8'h01, 16'd4, 1'b1);
        put_desc(32'h140, 32'h180, 32'h240, 8'h09, 16'd4, 1'b0);
        put_desc(32'h180, 0,       32'h280, 8'h01, 16'd4, 1'b0);
        t0 = tx_n;
        run(32'h100);
        check("R1 first status", mem[32'h10C/4], 32'h8000_0004);
        check("R6 unknown op status", mem[32'h14C/4], 32'hC000_0000);
        check("R1 third status", mem[32'h18C/4], 32'h8000_0004);
        check("R6 tx count skips unknown", tx_n - t0, 32'd2);
        check("R1 tx order", tx_log[(t0 + 1) % 64], 32'h7702);
        check("R8 irq held after no-stall run", {31'd0, irq}, 32'h1);
        reg_rd(2'd2, r);
        check("R10 state keeps last descriptor", r, 32'h180);
        reg_wr(2'd3, 32'h0);
        @(negedge clk);
        check("R9 irq cleared by ack write", {31'd0, irq}, 32'h0);

        // start while busy is ignored
        put_desc(32'h100, 0, 32'h200, 8'h02, 16'd4, 1'b0);
        put_desc(32'h140, 0, 32'h240, 8'h01, 16'd4, 1'b0);
        rx_en = 1'b0;
        reg_wr(2'd1, 32'h100);
        reg_wr(2'd0, 32'h1);
        repeat (20) @(negedge clk);
        reg_wr(2'd1, 32'h140);
        reg_wr(2'd0, 32'h1);
        rx_en = 1'b1;
        wait_stop();
        check("R2 second start ignored", mem[32'h14C/4], 32'h0);
        check("R2 first chain done", mem[32'h10C/4], 32'h8000_0004);
        reg_rd(2'd2, r);
        check("R2 state address from first head", r, 32'h100);

        // abort at descriptor boundary
        put_desc(32'h100, 32'h140, 32'h200, 8'h02, 16'd4, 1'b0);
        put_desc(32'h140, 0,       32'h240, 8'h01, 16'd4, 1'b0);
        rx_en = 1'b0;
        t0 = tx_n;
        reg_wr(2'd1, 32'h100);
        reg_wr(2'd0, 32'h1);
        repeat (20) @(negedge clk);
        reg_wr(2'd0, 32'h2);
        rx_en = 1'b1;
        wait_stop();
        check("R11 current descriptor completed", mem[32'h10C/4], 32'h8000_0004);
        check("R11 next descriptor untouched", mem[32'h14C/4], 32'h0);
        check("R11 no stream after abort", tx_n - t0, 32'd0);

        // memory error: buffer in fault region, link ignored
        put_desc(32'h100, 32'h140, 32'h400, 8'h01, 16'd8, 1'b0);
        put_desc(32'h140, 0,       32'h240, 8'h01, 16'd4, 1'b0);
        run(32'h100);
        check("R7 error status", mem[32'h10C/4], 32'hC000_0000);
        check("R7 stopped despite link", mem[32'h14C/4], 32'h0);

        // acknowledge in the same cycle as a new flagged completion
        put_desc(32'h100, 32'h140, 32'h200, 8'h01, 16'd4, 1'b1);
        put_desc(32'h140, 0,       32'h240, 8'h01, 16'd4, 1'b1);
        reg_wr(2'd1, 32'h100);
        reg_wr(2'd0, 32'h1);
        @(negedge clk);
        while (!(mem_ack && mem_we && mem_addr == 32'h14C)) @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = 2'd3;
        @(negedge clk);
        reg_en = 1'b0;
        check("R9 set wins over ack", {31'd0, irq}, 32'h1);
        wait_stop();
        reg_rd(2'd3, r);
        @(negedge clk);
        check("R9 final clear", {31'd0, irq}, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule